// File: doc/BRIEF.md
# Copy-and-Swap Bit Swizzle Unit

This block rearranges the bits of a 128-bit word under the control of two 7-bit index masks. A copy mask and a swap mask are applied to every result bit position. The position is ANDed with the copy mask, the outcome is XORed with the swap mask, and the value picked is the source bit at that index. This single rule gives full reversal, reversal of fields inside symbols, exchange of aligned blocks, identity, and replication of a field across the word, so a full crossbar is not needed.

The source word comes from two 64-bit operands. In pair mode the high operand fills bits 127..64 and the low operand fills bits 63..0. In splat mode the low operand fills both halves. The result is registered. A valid strobe follows the request strobe one cycle later. The result register loads only when a request is presented, so the previous result is held between requests.

Top module: `swz_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0.
- R3: For a request, `out_data[i]` in the next cycle equals `src[(i & ctl_copy) ^ ctl_swap]` for every i from 0 to 127. When `pair_mode` = 1, src = {`op_hi`, `op_lo`}, with `op_hi` in bits 127..64.
- R4: When `pair_mode` = 0, src = {`op_lo`, `op_lo`}, and `op_hi` has no effect on the result.
- R5: With `ctl_copy` = 127 and `ctl_swap` = 0, the result equals the source.
- R6: With `ctl_copy` = 127 and `ctl_swap` = 127, the result is the source with its bit order fully reversed.
- R7: With `ctl_copy` = 127 and `ctl_swap` = 112, result 16-bit block k (bits 16k+15..16k) equals source block 7-k, and bit order inside each block is kept.
- R8: With `ctl_copy` = 127 and `ctl_swap` = 1, each even result bit takes the odd source bit above it, and each odd result bit takes the even source bit below it.
- R9: With `ctl_copy` = 0, every result bit equals `src[ctl_swap]`, which broadcasts that one bit.
- R10: With `ctl_copy` = 7 and `ctl_swap` = 0, the low source byte is replicated into all 16 bytes of the result.
- R11: In a cycle with `in_valid` = 0, `out_data` keeps its value into the next cycle, whatever the operands and control values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; loads the result register |
| pair_mode | input | 1 | 1: use both operands; 0: copy the low operand into both halves |
| op_hi | input | 64 | Upper operand |
| op_lo | input | 64 | Lower operand |
| ctl_copy | input | 7 | Copy mask, ANDed with the result index |
| ctl_swap | input | 7 | Swap mask, XORed after the AND |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 128 | Registered swizzled result |

## Verification
The bench builds the unit with its default 64-bit half width, so the index masks are 7 bits wide. At that width every one of the 16384 copy/swap mask pairs can be driven, each with fresh random operands in pair mode, and every result is compared with an index model written in the bench. Directed scenarios pin down the named configurations (reversal, block exchange, pair exchange, broadcast, byte replication), the splat source, and the hold behaviour when no request is presented.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic {
    SRC_SPLAT = 1'b0,
    SRC_PAIR  = 1'b1
  } swz_src_e;

  // Source index for one result position: keep the index bits named by the
  // copy mask, then flip the bits named by the swap mask.
  function automatic logic [15:0] swz_fold(input logic [15:0] pos,
                                           input logic [15:0] cp,
                                           input logic [15:0] sw);
    return (pos & cp) ^ sw;
  endfunction

endpackage

// File: rtl/swz_source.sv
module swz_source #(
  parameter int HALF_W = 64,
  localparam int W = 2 * HALF_W
) (
  input  logic              pair_mode,
  input  logic [HALF_W-1:0] op_hi,
  input  logic [HALF_W-1:0] op_lo,
  output logic [W-1:0]      src_word
);
  import swz_pkg::*;

  swz_src_e sel;
  assign sel = swz_src_e'(pair_mode);

  always_comb begin
    unique case (sel)
      SRC_PAIR:  src_word = {op_hi, op_lo};
      default:   src_word = {op_lo, op_lo};
    endcase
  end
endmodule

// File: rtl/swz_net.sv
module swz_net #(
  parameter int HALF_W = 64,
  localparam int W = 2 * HALF_W,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     src_word,
  input  logic [IDX_W-1:0] ctl_copy,
  input  logic [IDX_W-1:0] ctl_swap,
  output logic [W-1:0]     net_result
);
  import swz_pkg::*;

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    logic [IDX_W-1:0] pick;
    assign pick = IDX_W'(swz_fold(16'(gi), 16'(ctl_copy), 16'(ctl_swap)));
    assign net_result[gi] = src_word[pick];
  end
endmodule

// File: rtl/swz_outreg.sv
module swz_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/swz_unit.sv
module swz_unit #(
  parameter int HALF_W = 64,
  localparam int W = 2 * HALF_W,
  localparam int IDX_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              pair_mode,
  input  logic [HALF_W-1:0] op_hi,
  input  logic [HALF_W-1:0] op_lo,
  input  logic [IDX_W-1:0]  ctl_copy,
  input  logic [IDX_W-1:0]  ctl_swap,
  output logic              out_valid,
  output logic [W-1:0]      out_data
);
  logic [W-1:0] src_word;
  logic [W-1:0] net_result;

  swz_source #(.HALF_W(HALF_W)) u_src (
    .pair_mode (pair_mode),
    .op_hi     (op_hi),
    .op_lo     (op_lo),
    .src_word  (src_word)
  );

  swz_net #(.HALF_W(HALF_W)) u_net (
    .src_word   (src_word),
    .ctl_copy   (ctl_copy),
    .ctl_swap   (ctl_swap),
    .net_result (net_result)
  );

  swz_outreg #(.W(W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .d       (net_result),
    .q_valid (out_valid),
    .q       (out_data)
  );
endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk #(
  parameter int HALF_W = 64,
  localparam int W = 2 * HALF_W,
  localparam int IDX_W = $clog2(W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              pair_mode,
  input logic [IDX_W-1:0]  ctl_copy,
  input logic [IDX_W-1:0]  ctl_swap,
  input logic [W-1:0]      src_word,
  input logic              out_valid,
  input logic [W-1:0]      out_data
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_LOW_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[0] == $past(src_word[ctl_swap])); // R3
  AST_HIGH_CORNER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[W-1] == $past(src_word[ctl_copy ^ ctl_swap])); // R3
  AST_SPLAT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pair_mode && ctl_copy[IDX_W-1]) |=> out_data[0] == out_data[HALF_W]); // R4
  AST_BROADCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ctl_copy == '0) |=> (out_data == '0 || out_data == '1)); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R11
endmodule

bind swz_unit swz_unit_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .pair_mode (pair_mode),
  .ctl_copy  (ctl_copy),
  .ctl_swap  (ctl_swap),
  .src_word  (src_word),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/swz_unit_tb.sv
module swz_unit_tb;
  localparam int HW = 64;
  localparam int W  = 2 * HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          pair_mode = 1'b1;
  logic [HW-1:0] op_hi = '0;
  logic [HW-1:0] op_lo = '0;
  logic [6:0]    ctl_copy = '0;
  logic [6:0]    ctl_swap = '0;
  logic          out_valid;
  logic [W-1:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  swz_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pair_mode(pair_mode),
    .op_hi(op_hi), .op_lo(op_lo), .ctl_copy(ctl_copy), .ctl_swap(ctl_swap),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // Bench index model: build the source position bit by bit.
  function automatic logic [W-1:0] model(logic [W-1:0] s, logic [6:0] cp, logic [6:0] sw);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      int k = 0;
      for (int b = 0; b < 7; b++)
        if ((((i >> b) & 1) != 0 && cp[b]) != sw[b]) k += (1 << b);
      r[i] = s[k];
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; return at the next falling edge with the result registered.
  task automatic apply(bit pm, logic [63:0] hi, logic [63:0] lo, logic [6:0] cp, logic [6:0] sw);
    in_valid = 1'b1; pair_mode = pm; op_hi = hi; op_lo = lo;
    ctl_copy = cp; ctl_swap = sw;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid", W'(out_valid), '0);
    check("R1 data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", out_data | W'(out_valid), '0);
  endtask

  task automatic t_latency();
    apply(1, 64'h1, 64'h2, 7'd127, 7'd0);
    check("R2 valid high", W'(out_valid), W'(1));
    @(negedge clk);
    check("R2 valid low", W'(out_valid), '0);
  endtask

  task automatic t_identity();
    logic [63:0] h = rnd64(), l = rnd64();
    apply(1, h, l, 7'd127, 7'd0);
    check("R5 identity", out_data, {h, l});
  endtask

  task automatic t_reverse();
    logic [63:0] h = rnd64(), l = rnd64();
    logic [W-1:0] s = {h, l}, e;
    for (int i = 0; i < W; i++) e[i] = s[W-1-i];
    apply(1, h, l, 7'd127, 7'd127);
    check("R6 reversal", out_data, e);
  endtask

  task automatic t_blocks();
    logic [63:0] h = rnd64(), l = rnd64();
    logic [W-1:0] s = {h, l}, e;
    for (int k = 0; k < 8; k++) e[16*k +: 16] = s[16*(7-k) +: 16];
    apply(1, h, l, 7'd127, 7'd112);
    check("R7 block exchange", out_data, e);
  endtask

  task automatic t_pairs();
    logic [63:0] h = rnd64(), l = rnd64();
    logic [W-1:0] s = {h, l}, e;
    for (int i = 0; i < W; i += 2) begin e[i] = s[i+1]; e[i+1] = s[i]; end
    apply(1, h, l, 7'd127, 7'd1);
    check("R8 pair exchange", out_data, e);
  endtask

  task automatic t_broadcast();
    logic [63:0] h = 64'h8000_0000_0000_0000, l = 64'h0000_0000_0000_0020;
    apply(1, h, l, 7'd0, 7'd127);
    check("R9 broadcast ones", out_data, '1);
    apply(1, h, l, 7'd0, 7'd4);
    check("R9 broadcast zeros", out_data, '0);
    apply(1, h, l, 7'd0, 7'd5);
    check("R9 broadcast bit5", out_data, '1);
  endtask

  task automatic t_bytes();
    logic [63:0] h = rnd64(), l = rnd64();
    apply(1, h, l, 7'd7, 7'd0);
    check("R10 byte replicate", out_data, {16{l[7:0]}});
  endtask

  task automatic t_splat();
    logic [63:0] h = rnd64(), l = rnd64();
    apply(0, h, l, 7'd127, 7'd0);
    check("R4 splat identity", out_data, {l, l});
    apply(0, ~h, l, 7'd127, 7'd127);
    check("R4 splat reversal", out_data, model({l, l}, 7'd127, 7'd127));
    apply(0, h, l, 7'd127, 7'd64);
    check("R4 splat half swap", out_data, {l, l});
  endtask

  task automatic t_hold();
    logic [63:0] h = rnd64(), l = rnd64();
    logic [W-1:0] kept;
    apply(1, h, l, 7'd127, 7'd0);
    kept = out_data;
    in_valid = 1'b0; op_hi = ~h; op_lo = ~l; ctl_swap = 7'd127;
    @(negedge clk);
    check("R11 hold", out_data, kept);
    check("R11 valid low", W'(out_valid), '0);
  endtask

  task automatic t_sweep();
    for (int cp = 0; cp < 128; cp++)
      for (int sw = 0; sw < 128; sw++) begin
        logic [63:0] h = rnd64(), l = rnd64();
        apply(1, h, l, 7'(cp), 7'(sw));
        check("R3 sweep", out_data, model({h, l}, 7'(cp), 7'(sw)));
      end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latency();
    t_identity();
    t_reverse();
    t_blocks();
    t_pairs();
    t_broadcast();
    t_bytes();
    t_splat();
    t_hold();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule